// File: doc/BRIEF.md
# Processor Presence Bitmap Window

This block keeps one presence bit for each processor in the system, indexed by the processor's interrupt-controller ID. It exposes the bits as a small byte-wide register window. Firmware reads the window one byte at a time to find which processors exist. An external hot-add request sets the bit for the new processor, latches a general-purpose event status bit, and drives the system control interrupt while that status bit is enabled.

The window is read-only. The only write that has an effect is a value of zero landing in the first 32-bit word of the window. The four byte writes to offsets 0 to 3 are gathered in any order. When the write that completes the set leaves the word equal to zero, the block moves into modern mode and stays there. From then on it stops answering on the window, ignores hot-add requests, and raises `modern_mode`, so that a neighbouring register file can take over the same addresses.

There are two resets. Power-on reset restores legacy mode and an empty map, except for the boot processor. Warm reset clears only the event status, the partial word collection and the read path. Warm reset keeps the map and the mode.

Top module: `cpu_presence_port`

## Requirements
- R1: After power-on reset, `modern_mode` is 0 and `gpe_sts` and `sci` are 0. Byte 0 of the window reads 0x01 and every other byte reads 0x00.
- R2: A hot-add with `hotadd_id` below NUM_CPUS, accepted in legacy mode, sets bit `hotadd_id % 8` of window byte `hotadd_id / 8`. IDs at or above NUM_CPUS are ignored.
- R3: A read in legacy mode (`acc_valid`=1, `acc_write`=0) returns the addressed byte on `rd_data`, with `rd_valid`=1, on the cycle after the request. Outside that cycle `rd_valid` is 0 and `rd_data` is 0x00.
- R4: Bit 0 of window byte 0 always reads 1, since it represents the boot processor.
- R5: Writes to any window byte never change the map. Presence bits are never cleared except by power-on reset.
- R6: An accepted hot-add sets `gpe_sts` on the next cycle. `gpe_sts` stays set until a `gpe_clr` pulse arrives with no hot-add in the same cycle. When both arrive together, the set wins.
- R7: `sci` equals `gpe_sts` AND `gpe_en` at all times.
- R8: Byte writes to offsets 0 to 3 are collected in any order, and a later write to the same offset replaces the earlier value. When the write that completes all four offsets leaves all four bytes at zero, `modern_mode` rises on the next cycle.
- R9: If the word is completed with any non-zero byte, the mode does not change and collection starts over. Writes to offsets 4 and above take no part in the collection.
- R10: Once set, `modern_mode` stays 1 through any number of warm resets. Only power-on reset clears it.
- R11: In modern mode, reads produce no `rd_valid` and `rd_data` stays 0x00. Hot-add requests neither set `gpe_sts` nor alter the map.
- R12: Warm reset clears `gpe_sts` and discards any partially collected word, but keeps the map contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Warm reset, active low, asynchronous |
| acc_valid | input | 1 | Window access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Byte offset in the window |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 8 | Read data byte |
| hotadd_valid | input | 1 | Hot-add request pulse |
| hotadd_id | input | 8 | Interrupt-controller ID of the added processor |
| gpe_en | input | 1 | Event enable bit |
| gpe_clr | input | 1 | Write-one-to-clear pulse for the event status |
| gpe_sts | output | 1 | Event status bit |
| sci | output | 1 | System control interrupt |
| modern_mode | output | 1 | 1 once the unit has switched to modern mode |

## Verification
The assertions assume four things about the inputs. Only one window access arrives per cycle. Both resets are low from time zero until the first clock edges have passed. Warm reset does not fall in the cycle right after a read request. A hot-add ID indexes the map directly. The stimulus keeps to these rules by driving every request for one cycle just after the rising edge and then leaving an idle cycle. It changes the resets only between requests, and with the default width every 8-bit ID it uses is in range. The reference model sees the same inputs, so the zero-word collection can be checked in order, out of order, with overwrites, and across a warm reset.

// File: rtl/cpu_presence_pkg.sv
`timescale 1ns/1ps
package cpu_presence_pkg;

    localparam int WORD_BYTES = 4;

    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_MODERN = 1'b1
    } hp_mode_e;

    typedef struct packed {
        logic [WORD_BYTES-1:0][7:0] shadow;
        logic [WORD_BYTES-1:0]      seen;
    } word_collect_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } rd_state_t;

endpackage

// File: rtl/cpu_presence_map.sv
`timescale 1ns/1ps
module cpu_presence_map
    import cpu_presence_pkg::*;
#(
    parameter int NUM_CPUS = 256,
    parameter int ID_W     = 8,
    parameter int ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_n,
    input  logic              add_en,
    input  logic [ID_W-1:0]   add_id,
    output logic              add_ok,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    localparam int MAP_BYTES = NUM_CPUS / 8;

    logic [NUM_CPUS-1:0]       map_d, map_q;
    logic [MAP_BYTES-1:0][7:0] map_bytes;
    rd_state_t                 rd_d, rd_q;

    for (genvar b = 0; b < MAP_BYTES; b++) begin : g_bytes
        assign map_bytes[b] = map_q[b*8 +: 8];
    end

    assign add_ok = add_en && ({1'b0, add_id} < (ID_W+1)'(NUM_CPUS));

    always_comb begin
        map_d = map_q;
        for (int i = 0; i < NUM_CPUS; i++) begin
            if (add_ok && (add_id == ID_W'(i))) begin
                map_d[i] = 1'b1;
            end
        end
        map_d[0] = 1'b1;

        rd_d.valid = rd_en;
        rd_d.data  = rd_en ? map_bytes[rd_addr] : 8'h00;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            map_q <= {{(NUM_CPUS-1){1'b0}}, 1'b1};
        end else begin
            map_q <= map_d;
        end
    end

    always_ff @(posedge clk or negedge warm_n) begin
        if (!warm_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    // Presence bit set after an accepted hot-add
    assert_hotadd_sets_bit_R2: assert property (@(posedge clk) disable iff (!por_n)
        add_ok |=> map_q[$past(add_id)]);

    // Without a hot-add the map never moves
    assert_map_holds_R5: assert property (@(posedge clk) disable iff (!por_n)
        !add_ok |=> $stable(map_q));

    // Idle read path carries zero
    assert_rd_idle_zero_R3: assert property (@(posedge clk) disable iff (!warm_n)
        !rd_en |=> (rd_data == 8'h00) && !rd_valid);

endmodule

// File: rtl/legacy_mode_latch.sv
`timescale 1ns/1ps
module legacy_mode_latch
    import cpu_presence_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              modern
);
    localparam int SEL_W = $clog2(WORD_BYTES);

    hp_mode_e      mode_d, mode_q;
    word_collect_t coll_d, coll_q;
    logic          hit;
    logic [SEL_W-1:0] sel;

    assign hit = wr_en && (mode_q == MODE_LEGACY) && (wr_addr < ADDR_W'(WORD_BYTES));
    assign sel = wr_addr[SEL_W-1:0];

    always_comb begin
        mode_d = mode_q;
        coll_d = coll_q;
        if (hit) begin
            coll_d.shadow[sel] = wr_data;
            coll_d.seen[sel]   = 1'b1;
            if (&coll_d.seen) begin
                if (coll_d.shadow == '0) begin
                    mode_d = MODE_MODERN;
                end
                coll_d.seen = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mode_q <= MODE_LEGACY;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_ff @(posedge clk or negedge warm_n) begin
        if (!warm_n) begin
            coll_q <= '0;
        end else begin
            coll_q <= coll_d;
        end
    end

    assign modern = (mode_q == MODE_MODERN);

    // One-way switch
    assert_mode_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
        modern |=> modern);

    // The switch only follows a collected word write
    assert_switch_on_write_R8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(modern) |-> $past(hit));

    // Writes outside the first word never switch
    assert_far_write_no_switch_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!modern && !hit) |=> !modern);

endmodule

// File: rtl/hotplug_gpe.sv
`timescale 1ns/1ps
module hotplug_gpe (
    input  logic clk,
    input  logic warm_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic sts,
    output logic sci
);
    logic sts_d, sts_q;

    always_comb begin
        sts_d = sts_q;
        if (set) begin
            sts_d = 1'b1;
        end else if (clr) begin
            sts_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge warm_n) begin
        if (!warm_n) begin
            sts_q <= 1'b0;
        end else begin
            sts_q <= sts_d;
        end
    end

    assign sts = sts_q;
    assign sci = sts_q & en;

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!warm_n)
        set |=> sts);

    assert_status_holds_R6: assert property (@(posedge clk) disable iff (!warm_n)
        (sts && !clr) |=> sts);

    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!warm_n)
        (clr && !set) |=> !sts);

    assert_sci_needs_enable_R7: assert property (@(posedge clk) disable iff (!warm_n)
        !en |-> !sci);

endmodule

// File: rtl/cpu_presence_port.sv
`timescale 1ns/1ps
module cpu_presence_port
    import cpu_presence_pkg::*;
#(
    parameter int NUM_CPUS = 256,
    parameter int ID_W     = 8,
    localparam int ADDR_W  = $clog2(NUM_CPUS / 8)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    input  logic              hotadd_valid,
    input  logic [ID_W-1:0]   hotadd_id,
    input  logic              gpe_en,
    input  logic              gpe_clr,
    output logic              gpe_sts,
    output logic              sci,
    output logic              modern_mode
);
    logic warm_n;
    logic rd_en, wr_en, add_en, add_ok;

    assign warm_n = por_n & rst_n;
    assign rd_en  = acc_valid && !acc_write && !modern_mode;
    assign wr_en  = acc_valid &&  acc_write && !modern_mode;
    assign add_en = hotadd_valid && !modern_mode;

    cpu_presence_map #(
        .NUM_CPUS (NUM_CPUS),
        .ID_W     (ID_W),
        .ADDR_W   (ADDR_W)
    ) i_map (
        .clk      (clk),
        .por_n    (por_n),
        .warm_n   (warm_n),
        .add_en   (add_en),
        .add_id   (hotadd_id),
        .add_ok   (add_ok),
        .rd_en    (rd_en),
        .rd_addr  (acc_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    legacy_mode_latch #(
        .ADDR_W (ADDR_W)
    ) i_mode (
        .clk     (clk),
        .por_n   (por_n),
        .warm_n  (warm_n),
        .wr_en   (wr_en),
        .wr_addr (acc_addr),
        .wr_data (acc_wdata),
        .modern  (modern_mode)
    );

    hotplug_gpe i_gpe (
        .clk    (clk),
        .warm_n (warm_n),
        .set    (add_ok),
        .clr    (gpe_clr),
        .en     (gpe_en),
        .sts    (gpe_sts),
        .sci    (sci)
    );

    assert_read_answers_R3: assert property (@(posedge clk) disable iff (!warm_n)
        (acc_valid && !acc_write && !modern_mode) |=> rd_valid);

    assert_boot_bit_R4: assert property (@(posedge clk) disable iff (!warm_n)
        (acc_valid && !acc_write && !modern_mode && acc_addr == '0) |=> rd_data[0]);

    assert_modern_silent_R11: assert property (@(posedge clk) disable iff (!warm_n)
        modern_mode |=> !rd_valid);

    assert_modern_no_event_R11: assert property (@(posedge clk) disable iff (!warm_n)
        (modern_mode && !gpe_sts) |=> !gpe_sts);

endmodule

// File: tb/test_cpu_presence_port.sv
`timescale 1ns/1ps
module test_cpu_presence_port;
    localparam int NUM = 256;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       acc_valid = 1'b0, acc_write = 1'b0;
    logic [4:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       hotadd_valid = 1'b0;
    logic [7:0] hotadd_id = '0;
    logic       gpe_en = 1'b0, gpe_clr = 1'b0;
    logic       gpe_sts, sci, modern_mode;

    int errors = 0;
    int checks = 0;
    bit run = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cpu_presence_port i_cpu_presence_port (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .hotadd_valid(hotadd_valid), .hotadd_id(hotadd_id),
        .gpe_en(gpe_en), .gpe_clr(gpe_clr), .gpe_sts(gpe_sts),
        .sci(sci), .modern_mode(modern_mode)
    );

    // Behavioural reference model
    bit       m_map [NUM];
    bit       m_mode, m_sts, m_rdv;
    bit [7:0] m_rdd;
    bit [7:0] m_shadow [4];
    bit       m_seen [4];

    always @(posedge clk or negedge por_n or negedge rst_n) begin
        if (!por_n) begin
            foreach (m_map[i]) m_map[i] = (i == 0);
            m_mode = 0; m_sts = 0; m_rdv = 0; m_rdd = 0;
            foreach (m_seen[i]) m_seen[i] = 0;
        end else if (!rst_n) begin
            m_sts = 0; m_rdv = 0; m_rdd = 0;
            foreach (m_seen[i]) m_seen[i] = 0;
        end else begin
            bit legacy;
            legacy = !m_mode;
            m_rdv = legacy && acc_valid && !acc_write;
            m_rdd = 0;
            if (m_rdv)
                for (int k = 0; k < 8; k++) m_rdd[k] = m_map[int'(acc_addr) * 8 + k];
            if (legacy && hotadd_valid && int'(hotadd_id) < NUM) begin
                m_map[hotadd_id] = 1;
                m_sts = 1;
            end else if (gpe_clr) begin
                m_sts = 0;
            end
            if (legacy && acc_valid && acc_write && acc_addr < 4) begin
                bit all_seen, all_zero;
                m_shadow[acc_addr[1:0]] = acc_wdata;
                m_seen[acc_addr[1:0]] = 1;
                all_seen = 1; all_zero = 1;
                for (int k = 0; k < 4; k++) begin
                    if (!m_seen[k]) all_seen = 0;
                    if (m_shadow[k] != 0) all_zero = 0;
                end
                if (all_seen) begin
                    if (all_zero) m_mode = 1;
                    for (int k = 0; k < 4; k++) m_seen[k] = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run && !done) begin
            chk(rd_valid == m_rdv, "R3 rd_valid", rd_valid, m_rdv);
            chk(rd_data == m_rdd, "R3 rd_data", rd_data, m_rdd);
            chk(gpe_sts == m_sts, "R6 gpe_sts", gpe_sts, m_sts);
            chk(sci == (m_sts && gpe_en), "R7 sci", sci, m_sts && gpe_en);
            chk(modern_mode == m_mode, "R8 modern_mode", modern_mode, m_mode);
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        acc_valid = 1; acc_write = 1; acc_addr = 5'(a); acc_wdata = 8'(d);
        @(posedge clk); #1;
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic rd(input int a, output logic [7:0] v, output logic vld);
        @(posedge clk); #1;
        acc_valid = 1; acc_write = 0; acc_addr = 5'(a);
        @(posedge clk); #1;
        acc_valid = 0;
        @(negedge clk);
        v = rd_data; vld = rd_valid;
    endtask

    task automatic hot_add(input int id, input bit clr);
        @(posedge clk); #1;
        hotadd_valid = 1; hotadd_id = 8'(id); gpe_clr = clr;
        @(posedge clk); #1;
        hotadd_valid = 0; gpe_clr = 0;
    endtask

    task automatic clear_evt();
        @(posedge clk); #1; gpe_clr = 1;
        @(posedge clk); #1; gpe_clr = 0;
    endtask

    task automatic warm_reset();
        @(posedge clk); #1; rst_n = 0;
        @(posedge clk); #1; rst_n = 1;
    endtask

    task automatic expect_byte(input int a, input int exp, input string tag);
        logic [7:0] v; logic vld;
        rd(a, v, vld);
        chk(vld === 1'b1 && v === 8'(exp), tag, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v; logic vld;
        repeat (3) @(posedge clk);
        #1; por_n = 1; rst_n = 1;
        run = 1;
        @(negedge clk);
        chk(modern_mode === 1'b0, "R1 mode after power-on", modern_mode, 0);
        chk(gpe_sts === 1'b0 && sci === 1'b0, "R1 event after power-on", gpe_sts, 0);
        expect_byte(0, 8'h01, "R1 R4 byte0 after power-on");
        expect_byte(31, 8'h00, "R1 byte31 after power-on");
        for (int a = 1; a < 31; a += 7) expect_byte(a, 8'h00, "R1 empty byte");

        hot_add(5, 0);
        @(negedge clk);
        chk(gpe_sts === 1'b1, "R6 status after hot-add", gpe_sts, 1);
        expect_byte(0, 8'h21, "R2 id 5 in byte0");
        @(posedge clk); #1; gpe_en = 1;
        @(negedge clk);
        chk(sci === 1'b1, "R7 sci with enable", sci, 1);
        @(posedge clk); #1; gpe_en = 0;
        @(negedge clk);
        chk(sci === 1'b0, "R7 sci without enable", sci, 0);
        hot_add(255, 0);
        expect_byte(31, 8'h80, "R2 id 255 in byte31");
        hot_add(8, 0);
        expect_byte(1, 8'h01, "R2 id 8 in byte1");
        hot_add(0, 0);
        expect_byte(0, 8'h21, "R2 R4 boot id re-add");

        clear_evt();
        @(negedge clk);
        chk(gpe_sts === 1'b0, "R6 clear", gpe_sts, 0);
        @(posedge clk); #1; gpe_en = 1;
        hot_add(9, 1);
        @(negedge clk);
        chk(gpe_sts === 1'b1, "R6 set wins over clear", gpe_sts, 1);
        expect_byte(1, 8'h03, "R2 id 9 in byte1");

        wr(31, 8'h00);
        wr(0, 8'h00);
        wr(1, 8'hFF);
        expect_byte(0, 8'h21, "R5 R4 byte0 after writes");
        expect_byte(31, 8'h80, "R5 byte31 after write");
        expect_byte(1, 8'h03, "R5 byte1 after write");

        wr(2, 0); wr(3, 0);
        @(negedge clk);
        chk(modern_mode === 1'b0, "R9 non-zero word keeps legacy", modern_mode, 0);
        for (int a = 4; a < 8; a++) wr(a, 0);
        @(negedge clk);
        chk(modern_mode === 1'b0, "R9 far writes ignored", modern_mode, 0);
        wr(0, 0); wr(1, 0); wr(2, 0);
        @(negedge clk);
        chk(modern_mode === 1'b0, "R9 three bytes do not switch", modern_mode, 0);

        warm_reset();
        @(negedge clk);
        chk(gpe_sts === 1'b0, "R12 status cleared by warm reset", gpe_sts, 0);
        expect_byte(0, 8'h21, "R12 map kept byte0");
        expect_byte(31, 8'h80, "R12 map kept byte31");
        wr(3, 0);
        @(negedge clk);
        chk(modern_mode === 1'b0, "R12 partial word discarded", modern_mode, 0);

        wr(2, 8'h05); wr(1, 0); wr(2, 0);
        @(negedge clk);
        chk(modern_mode === 1'b0, "R8 not yet complete", modern_mode, 0);
        wr(0, 0);
        @(negedge clk);
        chk(modern_mode === 1'b1, "R8 zero word switches", modern_mode, 1);

        rd(0, v, vld);
        chk(vld === 1'b0 && v === 8'h00, "R11 window silent", v, 0);
        hot_add(20, 0);
        @(negedge clk);
        chk(gpe_sts === 1'b0, "R11 hot-add ignored", gpe_sts, 0);

        warm_reset();
        @(negedge clk);
        chk(modern_mode === 1'b1, "R10 mode survives warm reset", modern_mode, 1);
        wr(0, 1); wr(1, 1); wr(2, 1); wr(3, 1);
        @(negedge clk);
        chk(modern_mode === 1'b1, "R10 mode sticky", modern_mode, 1);

        @(posedge clk); #1; por_n = 0;
        @(posedge clk); #1; por_n = 1;
        @(negedge clk);
        chk(modern_mode === 1'b0, "R1 power-on restores legacy", modern_mode, 0);
        expect_byte(0, 8'h01, "R1 power-on byte0");
        expect_byte(31, 8'h00, "R1 power-on byte31");
        expect_byte(2, 8'h00, "R1 R11 id 20 absent");

        repeat (2) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule